// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a single-port synchronous memory. Each word is split into byte lanes, and each lane holds 8 data bits plus 1 parity bit. By default there are two lanes, which gives an 18-bit word. On every rising clock edge the block captures:

- the address,
- the write data,
- a select input,
- a processor-start strobe,
- an all-lanes write override,
- a byte-write qualifier,
- one enable per lane.

A selected cycle either writes some lanes at the captured address or reads the word there. A write finishes inside the same edge and needs no handshake.

Read data passes through one output register, so it appears one clock after the address is captured. An asynchronous output enable gates the result. In place of a high-impedance bus, the block drives a valid flag and forces the data to zero whenever it is not driving.

A small state machine tracks the output stage. It has two states:

- `OUT_IDLE`: the bus is released.
- `OUT_DRIVE`: the output register holds read data.

Its transitions are:

- `READ_HIT`: a selected read cycle moves the stage from any state to `OUT_DRIVE`.
- `RELEASE`: a deselected cycle or a write cycle moves it from any state to `OUT_IDLE`.

Because of `RELEASE`, the bus is freed one edge after the last read. This is the single-cycle deselect.

Top module: `pbw_sram`

## Requirements
- R1: After reset `rd_valid` is 0 and `rd_data` is 0.
- R2: With `sel`=1, `start_rd`=0 and `all_wr_n`=0, all 18 bits at `addr` are written from `wr_data`, whatever `byte_wr_n` and `lane_wr_n` are.
- R3: With `all_wr_n`=1, lane i is written only when `byte_wr_n`=0 and `lane_wr_n[i]`=0. Lane 0 is bits 8:0, with parity at bit 8. Lane 1 is bits 17:9, with parity at bit 17. Lanes that are not written keep their old contents.
- R4: A selected cycle with `all_wr_n`=1 that enables no lane (`byte_wr_n`=1, or `lane_wr_n`=2'b11) is a read.
- R5: A selected cycle with `start_rd`=1 is a read and writes no lane, whatever the write inputs are.
- R6: The word at the address of a read cycle appears on `rd_data` after the next rising edge. `rd_valid` is 1 at the same time if `out_en_n` is 0.
- R7: Reading an address in the cycle right after a write to it returns the newly written data.
- R8: When the cycle after a read is deselected (`sel`=0) or is a write, `rd_valid` is 0 and `rd_data` is 0 after that edge.
- R9: While `out_en_n` is 1, `rd_valid` and `rd_data` are 0 at once, with no clock edge needed. When `out_en_n` returns to 0, the held read data reappears.
- R10: A cycle with `sel`=0 writes nothing, even with `all_wr_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Selects the cycle (active high) |
| start_rd | input | 1 | Processor-start strobe; forces a read |
| addr | input | ADDR_W | Word address |
| wr_data | input | LANES*9 | Write data |
| all_wr_n | input | 1 | Active-low write of all lanes |
| byte_wr_n | input | 1 | Active-low qualifier for lane enables |
| lane_wr_n | input | LANES | Active-low per-lane write enables |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rd_data | output | LANES*9 | Read data, 0 when not valid |
| rd_valid | output | 1 | Read data is being driven |

## Verification
The assertions run on every cycle and cover the following:

- the strobe and deselect overrides never let a lane be written;
- an all-lanes write enables every lane;
- the output enable forces the valid flag low;
- the bus releases one edge after any cycle that is not a read.

Only the bench's scenarios can show that the stored contents are right. That covers partial lane merges, read-after-write data, the held data returning when the output enable is lowered again, and the fact that ignored writes leave memory untouched. The bench checks these against a reference array that it updates lane by lane.

// File: rtl/pbw_sram_pkg.sv
package pbw_sram_pkg;
    localparam int LANE_DW = 8;
    localparam int LANE_W  = LANE_DW + 1;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_DRIVE = 1'b1
    } out_state_t;
endpackage

// File: rtl/pbw_lane_decode.sv
module pbw_lane_decode #(
    parameter int LANES = 2
) (
    input  logic             sel,
    input  logic             start_rd,
    input  logic             all_wr_n,
    input  logic             byte_wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lane_wr,
    output logic             rd_cycle
);
    logic wr_ok;

    assign wr_ok = sel && !start_rd;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_wr[g] = wr_ok && (!all_wr_n || (!byte_wr_n && !lane_wr_n[g]));
    end

    assign rd_cycle = sel && (lane_wr == '0);
endmodule

// File: rtl/pbw_array.sv
module pbw_array
    import pbw_sram_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [LANES-1:0]        lane_wr,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_wr[g]) begin
                mem[addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/pbw_out_stage.sv
module pbw_out_stage
    import pbw_sram_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cycle,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              out_en_n,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    out_state_t        state_q, state_d;
    logic [WORD_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE:  state_d = rd_cycle ? OUT_DRIVE : OUT_IDLE;
            OUT_DRIVE: state_d = rd_cycle ? OUT_DRIVE : OUT_IDLE;
            default:   state_d = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_cycle) begin
                data_q <= rd_word;
            end
        end
    end

    always_comb begin
        rd_valid = (state_q == OUT_DRIVE) && !out_en_n;
        rd_data  = rd_valid ? data_q : '0;
    end

    AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rd_valid); // R9
    AST_RELEASE_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cycle |=> !rd_valid && rd_data == '0); // R8
endmodule

// File: rtl/pbw_sram.sv
module pbw_sram
    import pbw_sram_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  logic                    start_rd,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    all_wr_n,
    input  logic                    byte_wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    out_en_n,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_valid
);
    localparam int WORD_W = LANES * LANE_W;

    logic [LANES-1:0]  lane_wr;
    logic              rd_cycle;
    logic [WORD_W-1:0] rd_word;

    pbw_lane_decode #(.LANES(LANES)) u_dec (
        .sel       (sel),
        .start_rd  (start_rd),
        .all_wr_n  (all_wr_n),
        .byte_wr_n (byte_wr_n),
        .lane_wr_n (lane_wr_n),
        .lane_wr   (lane_wr),
        .rd_cycle  (rd_cycle)
    );

    AST_STROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sel && start_rd |-> lane_wr == '0); // R5
    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> lane_wr == '0); // R10
    AST_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        sel && !start_rd && !all_wr_n |-> &lane_wr); // R2
    AST_NO_LANE_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sel && all_wr_n && byte_wr_n |=> rd_valid || out_en_n); // R4

    pbw_array #(.LANES(LANES), .ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .addr    (addr),
        .wr_data (wr_data),
        .lane_wr (lane_wr),
        .rd_word (rd_word)
    );

    pbw_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_cycle (rd_cycle),
        .rd_word  (rd_word),
        .out_en_n (out_en_n),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_wr != '0) |=> !rd_valid); // R8
endmodule

// File: tb/sim_pbw_sram.sv
module sim_pbw_sram;
    localparam int LANES  = 2;
    localparam int ADDR_W = 6;
    localparam int W      = LANES * 9;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, start_rd = 1'b0, all_wr_n = 1'b1, byte_wr_n = 1'b1, out_en_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [W-1:0]      wr_data = '0;
    logic [LANES-1:0]  lane_wr_n = '1;
    logic [W-1:0]      rd_data;
    logic              rd_valid;

    logic [W-1:0] ref_mem [DEPTH];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pbw_sram #(.LANES(LANES), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .start_rd(start_rd), .addr(addr),
        .wr_data(wr_data), .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n),
        .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [LANES-1:0] lanes_hit(bit s, bit st, bit g, bit b, logic [LANES-1:0] l);
        logic [LANES-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[i] = s && !st && (!g || (!b && !l[i]));
        return r;
    endfunction

    function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] d, logic [LANES-1:0] hit);
        logic [W-1:0] r = old;
        for (int i = 0; i < LANES; i++)
            if (hit[i]) r[i*9 +: 9] = d[i*9 +: 9];
        return r;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(string tag, bit s, bit st, bit g, bit b, logic [LANES-1:0] l,
                      logic [ADDR_W-1:0] a, logic [W-1:0] d, bit oe);
        logic [LANES-1:0] hit;
        bit rd, ev;
        logic [W-1:0] ed;
        sel = s; start_rd = st; all_wr_n = g; byte_wr_n = b; lane_wr_n = l;
        addr = a; wr_data = d; out_en_n = oe;
        hit = lanes_hit(s, st, g, b, l);
        rd  = s && (hit == '0);
        ev  = rd && !oe;
        ed  = ev ? ref_mem[a] : '0;
        if (hit != '0) ref_mem[a] = merge(ref_mem[a], d, hit);
        @(posedge clk);
        @(negedge clk);
        chk(tag, {{(W-1){1'b0}}, rd_valid}, {{(W-1){1'b0}}, ev});
        chk(tag, rd_data, ed);
    endtask

    task automatic rd_op(string tag, logic [ADDR_W-1:0] a);
        op(tag, 1, 0, 1, 1, '1, a, '0, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk("R1", {{(W-1){1'b0}}, rd_valid}, '0);
        chk("R1", rd_data, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: all-lanes write overrides disabled lane enables
        for (int i = 0; i < DEPTH; i++)
            op("R2", 1, 0, 0, 1, '1, i[ADDR_W-1:0], W'(i * 1031 + 7), 0);
        rd_op("R2", 6'd3);
        rd_op("R2", 6'd60);

        // R3: only lane 0 written
        op("R3", 1, 0, 1, 0, 2'b10, 6'd5, 18'h3FFFF, 0);
        rd_op("R3", 6'd5);
        // R3: lane enable without qualifier writes nothing
        op("R3", 1, 0, 1, 1, 2'b00, 6'd9, 18'h2AAAA, 0);
        rd_op("R3", 6'd9);

        // R4: no lane enabled is a read
        op("R4", 1, 0, 1, 0, 2'b11, 6'd12, 18'h15555, 0);

        // R5: strobe forces read despite all-lanes write
        op("R5", 1, 1, 0, 0, 2'b00, 6'd14, 18'h00001, 0);
        rd_op("R5", 6'd14);

        // R7: read right after write returns new data
        op("R7", 1, 0, 0, 0, 2'b00, 6'd20, 18'h1BEEF, 0);
        rd_op("R7", 6'd20);
        rd_op("R6", 6'd21);

        // R8: deselect after read releases bus
        op("R8", 0, 0, 1, 1, '1, 6'd21, '0, 0);
        rd_op("R6", 6'd22);
        op("R8", 1, 0, 1, 0, 2'b01, 6'd23, 18'h0F0F0, 0);

        // R9: asynchronous output enable gating
        rd_op("R9", 6'd20);
        sel = 1'b0;
        out_en_n = 1'b1;
        #1;
        chk("R9", {{(W-1){1'b0}}, rd_valid}, '0);
        chk("R9", rd_data, '0);
        out_en_n = 1'b0;
        #1;
        chk("R9", {{(W-1){1'b0}}, rd_valid}, {{(W-1){1'b0}}, 1'b1});
        chk("R9", rd_data, ref_mem[20]);

        // R10: deselected write is ignored
        op("R10", 0, 0, 0, 0, 2'b00, 6'd7, 18'h3C3C3, 0);
        rd_op("R10", 6'd7);

        for (int n = 0; n < 3000; n++) begin
            bit s, st, g, b, oe, rdc;
            logic [LANES-1:0] l;
            logic [ADDR_W-1:0] a;
            s  = ($urandom % 8) != 0;
            st = ($urandom % 6) == 0;
            g  = ($urandom % 4) != 0;
            b  = $urandom % 2;
            oe = ($urandom % 8) == 0;
            l  = LANES'($urandom);
            a  = ADDR_W'($urandom % 8);
            rdc = s && (lanes_hit(s, st, g, b, l) == '0);
            op(rdc ? (st ? "R5" : "R6") : "R8", s, st, g, b, l, a, W'($urandom), oe);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule